// File: doc/BRIEF.md
# Write-Back Line Cache Controller

This block is a direct-mapped data cache with multi-word lines that sits between a processor's load/store port and a slow word-serial memory. It is split into two cooperating engines. The front engine looks up the tag and valid state for each single-word request, serves hits in the same cycle and, on a miss, issues a line command. The back engine sits idle until it receives such a command. When it does, it first copies the victim line out to memory if that line holds modified data, then reads the requested line in. Read misses and write misses take the same allocate path. A write that misses is merged into the freshly filled line, and that line is then marked modified.

The processor side is a valid/ready request channel. A request is taken on a cycle where `cpu_valid` and `cpu_ready` are both high. Read data is valid on `cpu_rdata` in that same cycle. While `cpu_valid` is high and `cpu_ready` is low, the requester must hold `cpu_we`, `cpu_addr` and `cpu_wdata` steady. The controller drops `cpu_ready` when it detects a miss and keeps it low until the fill is done. The held request then completes as a hit.

The memory side moves one word per beat. A beat completes on a cycle where `mem_req` and `mem_ack` are both high. Until that cycle the controller holds `mem_addr`, `mem_we` and `mem_wdata` steady.

Top module: `wbc_cache`

## Requirements
- R1: Reset clears every valid and modified flag. The first access to any address after reset is a miss that reads in four words and writes nothing back.
- R2: A read hit raises `cpu_ready` in the cycle the request is presented. It returns the most recent value written to that word and causes no memory beat.
- R3: A write hit is accepted in the cycle it is presented. It updates only the addressed word, marks the line modified and causes no memory beat.
- R4: A read miss whose victim is invalid or unmodified performs exactly four read beats and no write beat.
- R5: A read miss whose victim is modified writes all four victim words to memory before any read beat of the new line, for four write beats followed by four read beats.
- R6: A write miss with an unmodified victim reads the line in, then merges the written word and marks the line modified. A later eviction of that line writes it back.
- R7: A write miss with a modified victim writes the victim back, reads the new line in, then merges the written word.
- R8: `cpu_ready` stays low from the cycle a miss is seen until the fill has finished. The held request then completes as a hit, with no further memory beats.
- R9: Each line transfer starts at word offset 0 and steps through offsets 1, 2 and 3 in ascending order. Address, direction and write data stay steady until `mem_ack`.
- R10: A word address splits into three fields: word offset in bits [1:0], line index in bits [5:2] and tag in bits [11:6]. The memory address of a beat is {tag, index, offset}.
- R11: The words written back for a victim equal the latest values the processor wrote into that line. Words the processor did not write keep the values that were read in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request taken this cycle (hit) |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 12 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load is taken |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 12 | Word address of the beat |
| mem_wdata | output | 32 | Write-beat data |
| mem_rdata | input | 32 | Read-beat data, valid with mem_ack |
| mem_ack | input | 1 | Beat completes this cycle |

## Verification
A wrong modified flag does not show at once. It shows at the next eviction of that index: four write beats are missing or appear when none are expected, and a later reload of the evicted address returns stale data. A wrong tag or valid bit shows on the very next access to that index. Either a hit stalls and triggers a line fetch, or a true miss is answered at once with wrong data. The bench predicts beat counts, the order of beats, stall or no stall, and data for every access, so each fault is caught within one access of the line it corrupted.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2
  } front_st_t;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_EVICT = 2'd1,
    BS_LOAD  = 2'd2,
    BS_DONE  = 2'd3
  } back_st_t;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 6,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_valid,
  output logic             look_dirty,
  output logic [TAG_W-1:0] look_tag,
  input  logic             inst_en,
  input  logic [IDX_W-1:0] inst_idx,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  logic [NUM_LINES-1:0] vld_q;
  logic [NUM_LINES-1:0] drt_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        drt_q[g] <= 1'b0;
      end else if (inst_en && inst_idx == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        drt_q[g] <= 1'b0;
      end else if (mark_en && mark_idx == IDX_W'(g)) begin
        drt_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (inst_en && inst_idx == IDX_W'(g)) tag_q[g] <= inst_tag;
    end
  end

  assign look_valid = vld_q[look_idx];
  assign look_dirty = drt_q[look_idx];
  assign look_tag   = tag_q[look_idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int DEPTH     = NUM_LINES * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [OFF_W-1:0]  a_off,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [OFF_W-1:0]  b_off,
  output logic [WORD_W-1:0] b_rdata,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [OFF_W-1:0]  w_off,
  input  logic [WORD_W-1:0] w_data
);
  logic [WORD_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (w_en) arr[{w_idx, w_off}] <= w_data;
  end

  assign a_rdata = arr[{a_idx, a_off}];
  assign b_rdata = arr[{b_idx, b_off}];
endmodule

// File: rtl/wbc_front.sv
module wbc_front
  import wbc_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_we,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             look_valid,
  input  logic             look_dirty,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             cmd_ready,
  input  logic             fill_done,
  output logic             cpu_ready,
  output logic             cmd_valid,
  output logic             cmd_victim_dirty,
  output logic             store_hit
);
  front_st_t st_q, st_d;
  logic      hit;

  assign hit = look_valid && (look_tag == req_tag);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FS_IDLE:  if (cpu_valid && !hit) st_d = FS_ISSUE;
      FS_ISSUE: if (cmd_ready)         st_d = FS_WAIT;
      FS_WAIT:  if (fill_done)         st_d = FS_IDLE;
      default:                         st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  assign cpu_ready        = (st_q == FS_IDLE) && hit;
  assign cmd_valid        = (st_q == FS_ISSUE);
  assign cmd_victim_dirty = look_valid && look_dirty;
  assign store_hit        = cpu_valid && cpu_ready && cpu_we;
endmodule

// File: rtl/wbc_back.sv
module wbc_back
  import wbc_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int TAG_W      = 6,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int ADDR_W    = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [TAG_W-1:0]  cmd_victim_tag,
  input  logic              cmd_victim_dirty,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [OFF_W-1:0]  rd_off,
  input  logic [WORD_W-1:0] rd_data,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [OFF_W-1:0]  fill_off,
  output logic [WORD_W-1:0] fill_data,
  output logic              inst_en,
  output logic [TAG_W-1:0]  inst_tag,
  output logic              fill_done
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  back_st_t         st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] ntag_q, vtag_q;
  logic [OFF_W-1:0] beat_q;
  logic             take, beat_end, last_beat;

  assign take      = cmd_valid && cmd_ready;
  assign beat_end  = mem_req && mem_ack;
  assign last_beat = beat_end && (beat_q == LAST_OFF);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BS_IDLE:  if (take) st_d = cmd_victim_dirty ? BS_EVICT : BS_LOAD;
      BS_EVICT: if (last_beat) st_d = BS_LOAD;
      BS_LOAD:  if (last_beat) st_d = BS_DONE;
      BS_DONE:  st_d = BS_IDLE;
      default:  st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      beat_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) beat_q <= '0;
      else if (beat_end) beat_q <= beat_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      idx_q  <= cmd_idx;
      ntag_q <= cmd_tag;
      vtag_q <= cmd_victim_tag;
    end
  end

  assign cmd_ready = (st_q == BS_IDLE);
  assign mem_req   = (st_q == BS_EVICT) || (st_q == BS_LOAD);
  assign mem_we    = (st_q == BS_EVICT);
  assign mem_addr  = {(st_q == BS_EVICT) ? vtag_q : ntag_q, idx_q, beat_q};
  assign rd_idx    = idx_q;
  assign rd_off    = beat_q;
  assign mem_wdata = rd_data;

  assign fill_en   = (st_q == BS_LOAD) && beat_end;
  assign fill_idx  = idx_q;
  assign fill_off  = beat_q;
  assign fill_data = mem_rdata;
  assign inst_en   = (st_q == BS_LOAD) && last_beat;
  assign inst_tag  = ntag_q;
  assign fill_done = (st_q == BS_DONE);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache #(
  parameter int NUM_LINES  = 16,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 12,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              look_valid, look_dirty;
  logic [TAG_W-1:0]  look_tag;
  logic              cmd_valid, cmd_ready, cmd_victim_dirty;
  logic              store_hit, fill_done;
  logic [IDX_W-1:0]  rd_idx, fill_idx;
  logic [OFF_W-1:0]  rd_off, fill_off;
  logic [WORD_W-1:0] rd_data, fill_data;
  logic              fill_en, inst_en;
  logic [TAG_W-1:0]  inst_tag;
  logic              w_en;
  logic [IDX_W-1:0]  w_idx;
  logic [OFF_W-1:0]  w_off;
  logic [WORD_W-1:0] w_data;

  assign req_off = cpu_addr[OFF_W-1:0];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  wbc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .look_idx(req_idx), .look_valid(look_valid), .look_dirty(look_dirty), .look_tag(look_tag),
    .inst_en(inst_en), .inst_idx(fill_idx), .inst_tag(inst_tag),
    .mark_en(store_hit), .mark_idx(req_idx)
  );

  // Bus fills and processor store hits never overlap: the front engine
  // only accepts requests while the back engine is idle.
  assign w_en   = fill_en || store_hit;
  assign w_idx  = fill_en ? fill_idx  : req_idx;
  assign w_off  = fill_en ? fill_off  : req_off;
  assign w_data = fill_en ? fill_data : cpu_wdata;

  wbc_data_store #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk),
    .a_idx(req_idx), .a_off(req_off), .a_rdata(cpu_rdata),
    .b_idx(rd_idx), .b_off(rd_off), .b_rdata(rd_data),
    .w_en(w_en), .w_idx(w_idx), .w_off(w_off), .w_data(w_data)
  );

  wbc_front #(.TAG_W(TAG_W)) u_front (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .req_tag(req_tag),
    .look_valid(look_valid), .look_dirty(look_dirty), .look_tag(look_tag),
    .cmd_ready(cmd_ready), .fill_done(fill_done),
    .cpu_ready(cpu_ready), .cmd_valid(cmd_valid),
    .cmd_victim_dirty(cmd_victim_dirty), .store_hit(store_hit)
  );

  wbc_back #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_back (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(req_idx), .cmd_tag(req_tag),
    .cmd_victim_tag(look_tag), .cmd_victim_dirty(cmd_victim_dirty),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rd_idx(rd_idx), .rd_off(rd_off), .rd_data(rd_data),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_off(fill_off), .fill_data(fill_data),
    .inst_en(inst_en), .inst_tag(inst_tag), .fill_done(fill_done)
  );
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_victim_dirty
);
  localparam logic [OFF_W-1:0] LAST_OFF = '1;
  logic [OFF_W-1:0] off;
  assign off = mem_addr[OFF_W-1:0];

  AST_HIT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);  // R2

  AST_DIRTY_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_victim_dirty) |=> (mem_req && mem_we));  // R5

  AST_CLEAN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_victim_dirty) |=> (mem_req && !mem_we));  // R4

  AST_EVICT_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && off == LAST_OFF) |=> (mem_req && !mem_we));  // R7

  AST_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (off == '0));  // R9

  AST_BEAT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && off != LAST_OFF) |=>
      (mem_req && off == $past(off) + OFF_W'(1)));  // R9

  AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R9

  AST_WDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));  // R11

  AST_STALL_UNTIL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && mem_req) |-> !cpu_ready);  // R8
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_victim_dirty(cmd_victim_dirty)
);

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int MEMSZ = 1 << AW;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0;
  logic          cpu_ready;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #5 clk = ~clk;

  wbc_cache u_wbc_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  // {store, address, data}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 12'h010, 32'h0},          // read miss, invalid victim
    {1'b0, 12'h011, 32'h0},          // read hit
    {1'b1, 12'h012, 32'hDEAD0001},   // write hit
    {1'b0, 12'h012, 32'h0},          // read hit of stored word
    {1'b0, 12'h050, 32'h0},          // read miss, dirty victim
    {1'b0, 12'h012, 32'h0},          // reload evicted line
    {1'b1, 12'h093, 32'hBEEF0002},   // write miss, clean victim
    {1'b1, 12'h0D1, 32'hCAFE0003},   // write miss, dirty victim
    {1'b0, 12'h093, 32'h0},          // read miss, dirty victim
    {1'b1, 12'h3FF, 32'h12345678},   // write miss, other index
    {1'b0, 12'h3FC, 32'h0},          // read hit, untouched word
    {1'b0, 12'h0D1, 32'h0}           // read miss, clean victim
  };

  // Memory model and reference state
  logic [DW-1:0] ram  [MEMSZ];
  logic [DW-1:0] gold [MEMSZ];
  logic          m_val [16];
  logic          m_drt [16];
  logic [5:0]    m_tag [16];
  int wr_beats = 0, rd_beats = 0, order_err = 0, wdat_err = 0;
  int op_id = 0, seen_op = -1, beat_pos = 0;
  logic rd_seen = 1'b0;
  int cyc = 0;

  function automatic logic [DW-1:0] init_word(int i);
    return (32'(i) * 32'h00010003) ^ 32'hA5A50000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else if (mem_req && mem_ack) begin
      if (seen_op != op_id) begin
        seen_op = op_id;
        rd_seen = 1'b0;
        beat_pos = 0;
      end
      if (int'(mem_addr[1:0]) != (beat_pos % 4)) order_err++;
      beat_pos++;
      if (mem_we) begin
        if (rd_seen) order_err++;
        if (mem_wdata != gold[mem_addr]) wdat_err++;
        ram[mem_addr] = mem_wdata;
        wr_beats++;
      end else begin
        rd_seen = 1'b1;
        rd_beats++;
      end
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack   <= 1'b1;
      mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 1'b0;
      m_drt[i] = 1'b0;
      m_tag[i] = '0;
    end
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int idx, w0, r0, stalls;
    logic [5:0] tg;
    logic hit, vdirty;
    string req;
    logic [DW-1:0] got;
    idx = int'(a[5:2]);
    tg  = a[11:6];
    hit = m_val[idx] && (m_tag[idx] == tg);
    vdirty = m_val[idx] && m_drt[idx];
    if (hit) req = we ? "R3" : "R2";
    else if (we) req = vdirty ? "R7" : "R6";
    else req = vdirty ? "R5" : "R4";
    op_id++;
    w0 = wr_beats;
    r0 = rd_beats;
    stalls = 0;
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_we    = we;
    cpu_addr  = a;
    cpu_wdata = d;
    #1;
    while (!cpu_ready && stalls < 200) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    got = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
    if (we) gold[a] = d;
    if (!hit) begin
      m_val[idx] = 1'b1;
      m_tag[idx] = tg;
      m_drt[idx] = 1'b0;
    end
    if (we) m_drt[idx] = 1'b1;
    // R8: stall only on a miss; hits are taken at once
    check(hit ? (stalls == 0) : (stalls > 0), "R8", "stall cycles",
          DW'(stalls), hit ? 32'd0 : 32'd1);
    check((wr_beats - w0) == (vdirty && !hit ? 4 : 0), req, "write beats",
          DW'(wr_beats - w0), DW'(vdirty && !hit ? 4 : 0));
    check((rd_beats - r0) == (hit ? 0 : 4), req, "read beats",
          DW'(rd_beats - r0), DW'(hit ? 0 : 4));
    if (!we) check(got == gold[a], req, "load data", got, gold[a]);
  endtask

  initial begin
    logic [AW-1:0] a;
    for (int i = 0; i < MEMSZ; i++) begin
      ram[i]  = init_word(i);
      gold[i] = init_word(i);
    end
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: nothing valid, no traffic during reset
    check(!cpu_ready && !mem_req, "R1", "ready/req in reset",
          {30'd0, cpu_ready, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req, "R1", "req after reset", {31'd0, mem_req}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v][44], VEC[v][43:32], VEC[v][31:0]);
    end

    // R10: two addresses differing only in tag share an index and evict
    do_op(1'b0, 12'h7C4, 32'h0);
    do_op(1'b0, 12'hBC4, 32'h0);
    do_op(1'b0, 12'h7C7, 32'h0);
    check(ram[12'h7C4] == init_word(12'h7C4), "R10", "clean line untouched",
          ram[12'h7C4], init_word(12'h7C4));

    // R11: written-back values match processor stores
    check(ram[12'h012] == 32'hDEAD0001, "R11", "victim word in memory",
          ram[12'h012], 32'hDEAD0001);
    check(ram[12'h093] == 32'hBEEF0002, "R11", "merged store in memory",
          ram[12'h093], 32'hBEEF0002);
    check(wdat_err == 0, "R11", "write-back data mismatches", DW'(wdat_err), 32'd0);
    check(order_err == 0, "R9", "beat order faults", DW'(order_err), 32'd0);

    // R1: a second reset drops all lines, including modified ones
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < MEMSZ; i++) gold[i] = ram[i];
    a = 12'h3FF;
    do_op(1'b0, a, 32'h0);
    check(ram[12'h3FF] == init_word(12'h3FF), "R1", "lost store not written",
          ram[12'h3FF], init_word(12'h3FF));
    check(order_err == 0, "R9", "beat order after reset", DW'(order_err), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule